// File: doc/BRIEF.md
# Paged Serial Flash Write Sequencer

This block sits on the host side of a serial NOR flash. It takes a request to store a run of bytes starting at any byte address. It cuts the run into program operations, and no operation crosses a page boundary. It drives a byte-level SPI transfer engine to carry out each operation. Chip select belongs to this block. The transfer engine only moves one byte per handshake and returns the byte it received at the same time.

For every chunk the sequencer first sends a one-byte write-enable frame. It then sends a program frame, which carries the opcode, a 24-bit address and the chunk's data. After that it polls the flash status in separate frames until the busy bit clears, and only then starts the next chunk. A sector-erase request follows the same pattern: enable, then the erase frame, then polling. The bytes to program come from a ready/valid byte source. A poll limit set by the host ends a flash that never finishes: the block raises an error flag and returns to idle. The host must have erased the target area first, because programming can only clear bits.

States: `ST_IDLE` (waits for a request), `ST_WEN` (enable frame), `ST_GAP_A` (select high, chunk length loaded), `ST_OPC` (program or erase opcode), `ST_ADR` (three address bytes), `ST_DAT` (data bytes), `ST_GAP_B` (select high, poll count cleared), `ST_POLL` (status frame), `ST_GAP_C` (decides on the status), `ST_FIN` (done pulse), `ST_ERR` (poll limit reached).

Transitions:
- IDLE→WEN on an accepted request.
- IDLE→FIN on a write of zero length.
- WEN→GAP_A→OPC→ADR.
- ADR→DAT for a write, or ADR→GAP_B for an erase.
- DAT→GAP_B after the last byte of the chunk.
- GAP_B→POLL→GAP_C.
- GAP_C→POLL while busy is still set.
- GAP_C→ERR when busy is still set at the limit.
- GAP_C→WEN while bytes remain.
- GAP_C→FIN otherwise.
- FIN→IDLE and ERR→IDLE.

Top module: `flash_pgm_seq`

## Requirements
- R1: During and after reset `spi_cs_n` is 1, and `busy`, `done`, `err` and `x_start` are 0.
- R2: Each program frame and each erase frame follows its own one-byte frame containing 06h. `spi_cs_n` goes high between the two frames.
- R3: A program frame is the byte 02h, then the address as three bytes with the most significant byte first, then the data bytes. Data byte k lands at the start address plus k.
- R4: Each chunk's length is the smaller of the bytes remaining and 256 minus the low 8 bits of the current address, so no program frame crosses a 256-byte page.
- R5: A write that fits inside one page uses exactly one program frame.
- R6: After each program or erase frame, the block repeats status frames until bit 0 of the status byte (busy) reads 0. A status frame is 05h followed by one dummy byte 00h, and the status byte is the one received during the dummy byte. No new frame other than a status frame starts while busy reads 1.
- R7: An erase request sends 06h, then a frame of D8h and three address bytes, then polls. It consumes no source bytes.
- R8: `done` is a single-cycle pulse after the final busy-clear status. `busy` is 0 in the cycle after it.
- R9: If the status byte shows busy at the `poll_limit`-th read of one wait, `err` goes to 1, the block returns to idle and `done` does not pulse. `err` stays 1 until the next request is accepted.
- R10: When `wr_req` and `er_req` are high in the same idle cycle, the write is taken and the erase is dropped.
- R11: Requests that arrive while `busy` is 1 are ignored.
- R12: A write of length 0 pulses `done` with no SPI frame.
- R13: At most one byte transfer is outstanding, and `x_start` is only asserted while `spi_cs_n` is 0.
- R14: Source bytes are taken in order, one per data transfer, with `src_ready` high only in the cycle the byte is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Start a write (sampled in idle) |
| wr_addr | input | 24 | Write start byte address |
| wr_len | input | LEN_W | Write length in bytes |
| er_req | input | 1 | Start a sector erase (sampled in idle) |
| er_addr | input | 24 | Address inside the sector to erase |
| poll_limit | input | TO_W | Maximum busy status reads per wait |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Source byte taken this cycle |
| spi_cs_n | output | 1 | Flash chip select, active low |
| x_start | output | 1 | Start one byte transfer |
| x_byte | output | 8 | Byte to shift out |
| x_done | input | 1 | Transfer finished |
| x_rx | input | 8 | Byte shifted in during that transfer |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | Operation complete pulse |
| err | output | 1 | Poll limit reached flag |

## Verification
Two functions can fall in the same cycle: accepting a write and accepting an erase. The bench raises `wr_req` and `er_req` together in one idle cycle. It then judges the result from the frame log kept by the flash model, which must show one program frame and no erase frame, and from the bytes stored at the write address. The bench also raises an erase request while a write is running, and expects the write to finish alone with no erase frame appearing afterwards.

// File: rtl/fps_pkg.sv
package fps_pkg;
    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_PP    = 8'h02;
    localparam logic [7:0] OP_SE    = 8'hD8;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_DUMMY = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WEN,
        ST_GAP_A,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_GAP_B,
        ST_POLL,
        ST_GAP_C,
        ST_FIN,
        ST_ERR
    } seq_state_t;
endpackage

// File: rtl/fps_chunk_plan.sv
module fps_chunk_plan #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  remain,
    output logic [LEN_W-1:0]  chunk_len
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int ROOM_W = PAGE_W + 1;
    localparam int CMP_W  = (LEN_W > ROOM_W) ? LEN_W : ROOM_W;

    logic [ROOM_W-1:0] room;
    logic [CMP_W-1:0]  room_w;
    logic [CMP_W-1:0]  rem_w;
    logic [CMP_W-1:0]  pick;

    always_comb begin
        // bytes left before the next page boundary
        room   = ROOM_W'(PAGE_BYTES) - {1'b0, cur_addr[PAGE_W-1:0]};
        room_w = CMP_W'(room);
        rem_w  = CMP_W'(remain);
        pick   = (rem_w < room_w) ? rem_w : room_w;
        chunk_len = LEN_W'(pick);
    end
endmodule

// File: rtl/fps_poll_guard.sv
module fps_poll_guard #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick,
    input  logic [TO_W-1:0] limit,
    output logic            last
);
    logic [TO_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // the busy read being judged is number cnt+1 of this wait
    assign last = ((TO_W+1)'({1'b0, cnt}) + (TO_W+1)'(1)) >= (TO_W+1)'({1'b0, limit});

    AST_GUARD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !(&cnt)); // R9
endmodule

// File: rtl/fps_xfer_track.sv
module fps_xfer_track (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic x_done,
    output logic x_start,
    output logic pend
);
    assign x_start = want && !pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (x_start)
            pend <= 1'b1;
        else if (x_done)
            pend <= 1'b0;
    end

    AST_DONE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        x_done |-> pend); // R13
endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
    import fps_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int TO_W       = 16,
    parameter int PAGE_BYTES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [23:0]      wr_addr,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             er_req,
    input  logic [23:0]      er_addr,
    input  logic [TO_W-1:0]  poll_limit,
    input  logic             src_valid,
    input  logic [7:0]       src_data,
    output logic             src_ready,
    output logic             spi_cs_n,
    output logic             x_start,
    output logic [7:0]       x_byte,
    input  logic             x_done,
    input  logic [7:0]       x_rx,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int PAGE_W     = $clog2(PAGE_BYTES);
    localparam logic [1:0] LAST_ADR_IDX = 2'(ADDR_BYTES - 1);

    seq_state_t      state, state_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  chunk_left;
    logic [LEN_W-1:0]  plan_len;
    logic [1:0]        idx;
    logic              mode_wr;
    logic              status_wip;
    logic              err_flag;
    logic              want;
    logic              pend;
    logic              poll_last;
    logic              accept;
    logic [ADDR_W-1:0] addr_sh;

    fps_chunk_plan #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) i_plan (
        .cur_addr (cur_addr),
        .remain   (remain),
        .chunk_len(plan_len)
    );

    fps_poll_guard #(
        .TO_W(TO_W)
    ) i_guard (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == ST_GAP_B),
        .tick (state == ST_GAP_C && status_wip),
        .limit(poll_limit),
        .last (poll_last)
    );

    fps_xfer_track i_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .want   (want),
        .x_done (x_done),
        .x_start(x_start),
        .pend   (pend)
    );

    assign accept = (state == ST_IDLE) && (wr_req || er_req);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_req)
                    state_nx = (wr_len == '0) ? ST_FIN : ST_WEN;
                else if (er_req)
                    state_nx = ST_WEN;
            end
            ST_WEN:   if (x_done) state_nx = ST_GAP_A;
            ST_GAP_A: state_nx = ST_OPC;
            ST_OPC:   if (x_done) state_nx = ST_ADR;
            ST_ADR: begin
                if (x_done && idx == LAST_ADR_IDX)
                    state_nx = mode_wr ? ST_DAT : ST_GAP_B;
            end
            ST_DAT: begin
                if (x_done && chunk_left == LEN_W'(1))
                    state_nx = ST_GAP_B;
            end
            ST_GAP_B: state_nx = ST_POLL;
            ST_POLL:  if (x_done && idx == 2'd1) state_nx = ST_GAP_C;
            ST_GAP_C: begin
                if (status_wip)
                    state_nx = poll_last ? ST_ERR : ST_POLL;
                else if (!mode_wr || remain == '0)
                    state_nx = ST_FIN;
                else
                    state_nx = ST_WEN;
            end
            ST_FIN:   state_nx = ST_IDLE;
            ST_ERR:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            remain     <= '0;
            chunk_left <= '0;
            idx        <= '0;
            mode_wr    <= 1'b0;
            status_wip <= 1'b0;
            err_flag   <= 1'b0;
        end else begin
            if (accept) begin
                cur_addr <= wr_req ? wr_addr : er_addr;
                remain   <= wr_req ? wr_len : '0;
                mode_wr  <= wr_req;
                err_flag <= 1'b0;
            end
            if (state == ST_GAP_A)
                chunk_left <= plan_len;
            if (state == ST_ADR || state == ST_POLL) begin
                if (x_done)
                    idx <= idx + 2'd1;
            end else begin
                idx <= '0;
            end
            if (state == ST_DAT && x_done) begin
                cur_addr   <= cur_addr + 1'b1;
                remain     <= remain - 1'b1;
                chunk_left <= chunk_left - 1'b1;
            end
            if (state == ST_POLL && x_done && idx == 2'd1)
                status_wip <= x_rx[0];
            if (state == ST_ERR)
                err_flag <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        addr_sh   = cur_addr >> {(LAST_ADR_IDX - idx), 3'b000};
        want      = 1'b0;
        x_byte    = OP_DUMMY;
        spi_cs_n  = 1'b1;
        unique case (state)
            ST_WEN: begin
                want = 1'b1; x_byte = OP_WEN; spi_cs_n = 1'b0;
            end
            ST_OPC: begin
                want = 1'b1; x_byte = mode_wr ? OP_PP : OP_SE; spi_cs_n = 1'b0;
            end
            ST_ADR: begin
                want = 1'b1; x_byte = addr_sh[7:0]; spi_cs_n = 1'b0;
            end
            ST_DAT: begin
                want = src_valid; x_byte = src_data; spi_cs_n = 1'b0;
            end
            ST_POLL: begin
                want = 1'b1; x_byte = (idx == 2'd0) ? OP_RDSR : OP_DUMMY; spi_cs_n = 1'b0;
            end
            default: ;
        endcase
        src_ready = (state == ST_DAT) && x_start;
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        err       = err_flag;
    end

    // checker state: an enable frame has gone out since the last program or erase opcode
    logic wen_armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wen_armed <= 1'b0;
        else if (x_start && x_byte == OP_WEN)
            wen_armed <= 1'b1;
        else if (x_start && state == ST_OPC)
            wen_armed <= 1'b0;
    end

    AST_WEN_BEFORE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (x_start && state == ST_OPC) |-> wen_armed); // R2
    AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        x_start |-> !spi_cs_n); // R13
    AST_CHUNK_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DAT && x_done && chunk_left != LEN_W'(1))
            |-> (cur_addr[PAGE_W-1:0] != '1)); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R8
    AST_ERR_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy); // R9
    AST_POLL_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP_C && status_wip && !poll_last) |=> (state == ST_POLL)); // R6
endmodule

// File: tb/test_flash_pgm_seq.sv
module test_flash_pgm_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int TO_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_req = 1'b0;
    logic [23:0]      wr_addr = '0;
    logic [LEN_W-1:0] wr_len = '0;
    logic             er_req = 1'b0;
    logic [23:0]      er_addr = '0;
    logic [TO_W-1:0]  poll_limit = 16'd50;
    logic             src_valid = 1'b1;
    logic [7:0]       src_data;
    logic             src_ready;
    logic             spi_cs_n;
    logic             x_start;
    logic [7:0]       x_byte;
    logic             x_done = 1'b0;
    logic [7:0]       x_rx = '0;
    logic             busy;
    logic             done;
    logic             err;

    flash_pgm_seq #(.LEN_W(LEN_W), .TO_W(TO_W)) i_flash_pgm_seq (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_len(wr_len),
        .er_req(er_req), .er_addr(er_addr), .poll_limit(poll_limit),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .spi_cs_n(spi_cs_n), .x_start(x_start), .x_byte(x_byte), .x_done(x_done),
        .x_rx(x_rx), .busy(busy), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // source and flash model state
    int src_ptr = 0;
    int busy_reads = 3;
    int wip_left = 0;
    bit wel = 0;
    int wen_n = 0, pp_n = 0, se_n = 0, rd_n = 0;
    int seq_bad = 0, page_bad = 0, ovl_bad = 0, wip_bad = 0;
    int done_cnt = 0, err_cnt = 0;
    logic [23:0] se_last = '0;
    logic [23:0] pp_addr_q[$];
    int          pp_len_q[$];
    logic [7:0]  fbuf[$];
    logic [7:0]  mem[int];
    logic        eng_busy = 0;
    logic [1:0]  eng_cnt = 0;
    logic [7:0]  rx_hold = 0;
    logic        cs_q = 1;

    function automatic logic [7:0] pat(int p);
        return 8'((p * 13 + 5) & 255);
    endfunction

    function automatic logic [7:0] rd_mem(int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    assign src_data = pat(src_ptr);

    function automatic void frame_end();
        logic [23:0] a;
        int n;
        if (fbuf.size() == 0) return;
        if (fbuf.size() >= 4) a = {fbuf[1], fbuf[2], fbuf[3]};
        else a = '0;
        case (fbuf[0])
            8'h06: begin wen_n++; wel = 1; end
            8'h02: begin
                pp_n++;
                if (!wel) seq_bad++;
                if (wip_left > 0) wip_bad++;
                n = fbuf.size() - 4;
                pp_addr_q.push_back(a);
                pp_len_q.push_back(n);
                if (n < 1 || int'(a[7:0]) + n > 256) page_bad++;
                for (int k = 0; k < n; k++)
                    mem[int'(a) + k] = rd_mem(int'(a) + k) & fbuf[4 + k];
                wel = 0;
                wip_left = busy_reads;
            end
            8'hD8: begin
                se_n++;
                if (!wel) seq_bad++;
                if (wip_left > 0) wip_bad++;
                se_last = a;
                wel = 0;
                wip_left = busy_reads;
            end
            8'h05: rd_n++;
            default: seq_bad++;
        endcase
        fbuf.delete();
    endfunction

    // byte engine plus flash model
    always @(posedge clk) begin
        x_done <= 1'b0;
        cs_q <= spi_cs_n;
        if (src_ready) src_ptr++;
        if (done) done_cnt++;
        if (busy && i_flash_pgm_seq.state_nx == i_flash_pgm_seq.state && 0) err_cnt = err_cnt;
        if (x_start) begin
            if (eng_busy || spi_cs_n) ovl_bad++;
            if (fbuf.size() == 1 && fbuf[0] == 8'h05) begin
                rx_hold <= (wip_left > 0) ? 8'h03 : 8'h02;
                if (wip_left > 0) wip_left--;
            end else begin
                rx_hold <= 8'h00;
            end
            fbuf.push_back(x_byte);
            eng_busy <= 1'b1;
            eng_cnt <= 2'd2;
        end else if (eng_busy) begin
            if (eng_cnt == 2'd1) begin
                x_done <= 1'b1;
                x_rx <= rx_hold;
                eng_busy <= 1'b0;
            end
            eng_cnt <= eng_cnt - 2'd1;
        end
        if (!cs_q && spi_cs_n) frame_end();
    end

    logic err_q = 0;
    always @(posedge clk) begin
        err_q <= err;
        if (err && !err_q) err_cnt++;
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_end(string tag);
        int d0 = done_cnt;
        int e0 = err_cnt;
        int n = 0;
        while (done_cnt == d0 && err_cnt == e0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) chk({tag, " completion"}, 0, 1);
    endtask

    task automatic start_write(logic [23:0] a, int len);
        @(negedge clk);
        wr_addr = a; wr_len = LEN_W'(len); wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cs_n", int'(spi_cs_n), 1);
        chk("R1 busy/done/err/start", int'({busy, done, err, x_start}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", int'({busy, done, err, x_start, !spi_cs_n}), 0);
    endtask

    task automatic t_one_page();
        int d0 = done_cnt, w0 = wen_n, p0 = pp_n, r0 = rd_n, s0 = src_ptr;
        int bad = 0;
        busy_reads = 3;
        pp_addr_q.delete(); pp_len_q.delete();
        start_write(24'h000105, 10);
        wait_end("R8 single page");
        chk("R8 busy low after done", int'(busy), 0);
        chk("R8 one done", done_cnt - d0, 1);
        chk("R5 one program frame", pp_n - p0, 1);
        chk("R2 one enable frame", wen_n - w0, 1);
        chk("R6 status frames", rd_n - r0, 4);
        chk("R3 frame address", int'(pp_addr_q[0]), 24'h000105);
        chk("R3 frame length", pp_len_q[0], 10);
        for (int k = 0; k < 10; k++)
            if (rd_mem(24'h000105 + k) != pat(s0 + k)) bad++;
        chk("R3 data stored", bad, 0);
    endtask

    task automatic t_multi_page();
        int p0 = pp_n, w0 = wen_n, s0 = src_ptr, bad = 0;
        busy_reads = 2;
        pp_addr_q.delete(); pp_len_q.delete();
        start_write(24'h0011F0, 300);
        wait_end("R4 multi page");
        chk("R4 program frames", pp_n - p0, 3);
        chk("R2 enable per chunk", wen_n - w0, 3);
        chk("R4 chunk0 len", pp_len_q[0], 16);
        chk("R4 chunk1 addr", int'(pp_addr_q[1]), 24'h001200);
        chk("R4 chunk1 len", pp_len_q[1], 256);
        chk("R4 chunk2 len", pp_len_q[2], 28);
        chk("R4 no page crossing", page_bad, 0);
        chk("R14 bytes consumed", src_ptr - s0, 300);
        for (int k = 0; k < 300; k++)
            if (rd_mem(24'h0011F0 + k) != pat(s0 + k)) bad++;
        chk("R14 data in order", bad, 0);
    endtask

    task automatic t_erase();
        int e0 = se_n, w0 = wen_n, r0 = rd_n, s0 = src_ptr, d0 = done_cnt;
        busy_reads = 4;
        @(negedge clk);
        er_addr = 24'h050123; er_req = 1'b1;
        @(negedge clk);
        er_req = 1'b0;
        wait_end("R7 erase");
        chk("R7 erase frames", se_n - e0, 1);
        chk("R7 erase address", int'(se_last), 24'h050123);
        chk("R7 enable frame", wen_n - w0, 1);
        chk("R7 no source bytes", src_ptr - s0, 0);
        chk("R6 erase polls", rd_n - r0, 5);
        chk("R7 done", done_cnt - d0, 1);
    endtask

    task automatic t_timeout();
        int r0 = rd_n, d0 = done_cnt;
        busy_reads = 100;
        poll_limit = 16'd5;
        start_write(24'h002000, 4);
        wait_end("R9 timeout");
        @(negedge clk);
        chk("R9 err set", int'(err), 1);
        chk("R9 idle", int'(busy), 0);
        chk("R9 no done", done_cnt - d0, 0);
        chk("R9 status reads", rd_n - r0, 5);
        repeat (5) @(negedge clk);
        chk("R9 err held", int'(err), 1);
        wip_left = 0;
        busy_reads = 2;
        poll_limit = 16'd50;
        start_write(24'h002100, 0);
        wait_end("R12 zero length");
        chk("R9 err cleared by request", int'(err), 0);
    endtask

    task automatic t_zero_len();
        int d0 = done_cnt, w0 = wen_n, p0 = pp_n, r0 = rd_n;
        start_write(24'h003000, 0);
        wait_end("R12 zero length");
        repeat (4) @(negedge clk);
        chk("R12 done pulse", done_cnt - d0, 1);
        chk("R12 no frames", (wen_n - w0) + (pp_n - p0) + (rd_n - r0), 0);
    endtask

    task automatic t_both_req();
        int p0 = pp_n, e0 = se_n, d0 = done_cnt;
        busy_reads = 1;
        @(negedge clk);
        wr_addr = 24'h004010; wr_len = LEN_W'(5); wr_req = 1'b1;
        er_addr = 24'h060000; er_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0; er_req = 1'b0;
        wait_end("R10 both");
        repeat (40) @(negedge clk);
        chk("R10 write taken", pp_n - p0, 1);
        chk("R10 erase dropped", se_n - e0, 0);
        chk("R10 single done", done_cnt - d0, 1);
    endtask

    task automatic t_busy_req();
        int p0 = pp_n, e0 = se_n, d0 = done_cnt;
        busy_reads = 2;
        start_write(24'h005000, 20);
        repeat (15) @(negedge clk);
        er_addr = 24'h070000; er_req = 1'b1;
        wr_addr = 24'h005800; wr_len = LEN_W'(3); wr_req = 1'b1;
        @(negedge clk);
        er_req = 1'b0; wr_req = 1'b0;
        wait_end("R11 busy request");
        repeat (60) @(negedge clk);
        chk("R11 no erase", se_n - e0, 0);
        chk("R11 one program", pp_n - p0, 1);
        chk("R11 one done", done_cnt - d0, 1);
    endtask

    initial begin
        t_reset();
        t_one_page();
        t_multi_page();
        t_erase();
        t_zero_len();
        t_both_req();
        t_busy_req();
        t_timeout();
        chk("R2 enable before every op", seq_bad, 0);
        chk("R6 no frame while flash busy", wip_bad, 0);
        chk("R13 transfer overlap", ovl_bad, 0);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule